// File: doc/BRIEF.md
# SPI-Attached CAN Controller Register Front-End

This block is the host-facing half of a CAN controller that is reached over SPI in mode 0 (clock idles low, data sampled on the rising edge, changed on the falling edge). Chip select frames each command. The first byte of a frame is an instruction. The bytes after it carry an address, data, or a mask, depending on the instruction. The block holds a register file of `1 << ADDR_W` bytes. It executes writes, reads, atomic masked bit updates, shortcut loads into the three transmit buffers, shortcut reads from the two receive buffers, request-to-send and a full register reset.

The CAN core sits on the other side of the register file. It reads any register combinationally. It writes received frames and other state through a valid/ready write port: a beat transfers on a rising clock edge where both `core_wr_valid` and `core_wr_ready` are high. The block drops `core_wr_ready` in any cycle in which the SPI side is writing or resetting the file. A core master must then hold its address and data stable until the handshake completes. The core also receives three one-cycle request-to-send strobes and the operating mode field taken from the control register.

SPI pins are synchronised into the core clock. The SCK high and low phases must each last at least 4 core clock cycles, and chip select must stay high for at least 4 core clock cycles between frames.

Top module: `can_spi_frontend`

## Requirements
- R1: After `rst_n` is released, every register reads 0x00 except control (index 0x0F), which reads 0x80. `op_mode` is 3'b100, `tx_rts` is 0, and `spi_miso` is 0.
- R2: Instruction 0x02 takes an address byte and then data bytes. The data bytes are written at that address and at the addresses that follow it, the address incrementing by one per byte. Address byte bit 7 is ignored, and the address wraps from 0x7F to 0x00.
- R3: Instruction 0x03 takes an address byte. The block then shifts out register contents MSB first, starting at that address and incrementing after each byte. Each bit is valid on `spi_miso` before the SCK rising edge that samples it.
- R4: Instruction 0x05 takes address, mask and data bytes. The register becomes (old AND NOT mask) OR (data AND mask).
- R5: Instructions 0x40, 0x42 and 0x44 take data bytes with no address byte. They write starting at 0x31, 0x41 and 0x51 respectively, with auto-increment.
- R6: Any instruction of the form 0x80 | b, with b in 0..7, pulses `tx_rts` to b for exactly one core clock cycle. Bit 0 selects transmit buffer 0, bit 1 selects buffer 1 and bit 2 selects buffer 2.
- R7: Instructions 0x90 and 0x94 take no address byte. They read out starting at 0x61 and 0x71 respectively, with auto-increment.
- R8: Instruction 0xC0 returns every register to its R1 value, so `op_mode` becomes 3'b100.
- R9: Any address whose low nibble is 0xF accesses the one control register. Any address whose low nibble is 0xE reads as {control[7:5], 5'b0}, and writes to it are ignored.
- R10: `op_mode` always equals control bits 7:5. The codes are 0 normal, 1 sleep, 2 loopback, 3 listen-only and 4 configuration.
- R11: Raising chip select abandons any partly received command or byte. A partial data byte is not written. The next frame starts with a fresh instruction byte.
- R12: An instruction byte not listed in R2 to R8 makes the block ignore the rest of the frame. No register changes, and `spi_miso` stays 0.
- R13: `core_rd_data` shows the register at `core_rd_addr` with the R9 mirroring applied. A core write transfers when `core_wr_valid` and `core_wr_ready` are both high, and follows the R9 address rules. `core_wr_ready` is low in every cycle in which an SPI write or an SPI reset changes the file, and the SPI access wins that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from host |
| spi_miso | output | 1 | SPI data to host, 0 when not reading |
| core_rd_addr | input | ADDR_W | Core read address |
| core_rd_data | output | 8 | Core read data (combinational) |
| core_wr_valid | input | 1 | Core write request |
| core_wr_ready | output | 1 | Core write accepted this cycle |
| core_wr_addr | input | ADDR_W | Core write address |
| core_wr_data | input | 8 | Core write data |
| tx_rts | output | 3 | One-cycle request-to-send strobes for transmit buffers 2..0 |
| op_mode | output | 3 | Operating mode, equal to control bits 7:5 |

## Verification
The bench uses the default parameters: ADDR_W = 7, giving the full 128-byte map, and SYNC_STAGES = 2. With these values, bursts can walk across the status/control mirror addresses and across the top-of-map wrap to 0x00 within a single frame. The SCK phase length is 8 core cycles. This leaves room for the two-stage synchroniser plus decode, so the bench can confirm that a read byte is ready before its first sampling edge. It also lets core writes collide with SPI writes, so the ready back-pressure can be observed.

// File: rtl/csf_pkg.sv
package csf_pkg;

  localparam logic [7:0] OP_WRITE  = 8'h02;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_BITMOD = 8'h05;
  localparam logic [7:0] OP_RX0    = 8'h90;
  localparam logic [7:0] OP_RX1    = 8'h94;
  localparam logic [7:0] OP_RESET  = 8'hC0;

  localparam logic [7:0] TX_BASE   = 8'h31;
  localparam logic [7:0] RX0_BASE  = 8'h61;
  localparam logic [7:0] RX1_BASE  = 8'h71;

  localparam logic [3:0] NIB_STATUS = 4'hE;
  localparam logic [3:0] NIB_CTRL   = 4'hF;
  localparam logic [7:0] CTRL_RESET = 8'h80;

  typedef enum logic [3:0] {
    ST_OPCODE,
    ST_WR_ADDR,
    ST_WR_DATA,
    ST_RD_ADDR,
    ST_RD_DATA,
    ST_BM_ADDR,
    ST_BM_MASK,
    ST_BM_DATA,
    ST_DISCARD
  } cmd_state_e;

endpackage

// File: rtl/csf_spi_link.sv
module csf_spi_link #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       mosi,
  input  logic [7:0] tx_byte,
  output logic       miso,
  output logic       link_active,
  output logic       byte_valid,
  output logic [7:0] byte_data
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sck_sync, cs_sync, mosi_sync;
  logic         sck_prev;
  logic [2:0]   bit_cnt;
  logic [6:0]   rx_shift;
  logic [7:0]   tx_shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sync  <= '0;
      cs_sync   <= '1;
      mosi_sync <= '0;
      sck_prev  <= 1'b0;
    end else begin
      sck_sync  <= {sck_sync[TOP-1:0], sck};
      cs_sync   <= {cs_sync[TOP-1:0], cs_n};
      mosi_sync <= {mosi_sync[TOP-1:0], mosi};
      sck_prev  <= sck_sync[TOP];
    end
  end

  logic sck_rise, sck_fall;
  assign link_active = !cs_sync[TOP];
  assign sck_rise    = sck_sync[TOP] && !sck_prev;
  assign sck_fall    = !sck_sync[TOP] && sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      rx_shift   <= '0;
      tx_shift   <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
    end else if (!link_active) begin
      bit_cnt    <= '0;
      tx_shift   <= '0;
      byte_valid <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      if (sck_rise) begin
        rx_shift <= {rx_shift[5:0], mosi_sync[TOP]};
        bit_cnt  <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_valid <= 1'b1;
          byte_data  <= {rx_shift, mosi_sync[TOP]};
        end
      end
      if (sck_fall) begin
        if (bit_cnt == 3'd0) tx_shift <= tx_byte;
        else                 tx_shift <= {tx_shift[6:0], 1'b0};
      end
    end
  end

  assign miso = link_active && tx_shift[7];

endmodule

// File: rtl/csf_cmd_decode.sv
module csf_cmd_decode
  import csf_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_active,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] ptr,
  output logic              wr_en,
  output logic [7:0]        wr_data,
  output logic              soft_reset,
  output logic [7:0]        tx_byte,
  output logic [2:0]        rts
);

  cmd_state_e state;
  logic [7:0] mask_q;

  logic is_load, is_rts;
  assign is_load = (byte_data[7:3] == 5'b01000) && !byte_data[0] &&
                   (byte_data[2:1] != 2'b11);
  assign is_rts  = (byte_data[7:3] == 5'b10000);

  assign wr_en = byte_valid && ((state == ST_WR_DATA) || (state == ST_BM_DATA));
  assign wr_data = (state == ST_BM_DATA) ?
                   ((rd_data & ~mask_q) | (byte_data & mask_q)) : byte_data;
  assign soft_reset = byte_valid && (state == ST_OPCODE) && (byte_data == OP_RESET);
  assign tx_byte = (state == ST_RD_DATA) ? rd_data : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_OPCODE;
      ptr    <= '0;
      mask_q <= '0;
      rts    <= '0;
    end else if (!link_active) begin
      state <= ST_OPCODE;
      rts   <= '0;
    end else begin
      rts <= '0;
      if (byte_valid) begin
        unique case (state)
          ST_OPCODE: begin
            if (byte_data == OP_WRITE)       state <= ST_WR_ADDR;
            else if (byte_data == OP_READ)   state <= ST_RD_ADDR;
            else if (byte_data == OP_BITMOD) state <= ST_BM_ADDR;
            else if (is_load) begin
              ptr   <= ADDR_W'(TX_BASE + {2'b00, byte_data[2:1], 4'h0});
              state <= ST_WR_DATA;
            end else if (byte_data == OP_RX0) begin
              ptr   <= ADDR_W'(RX0_BASE);
              state <= ST_RD_DATA;
            end else if (byte_data == OP_RX1) begin
              ptr   <= ADDR_W'(RX1_BASE);
              state <= ST_RD_DATA;
            end else begin
              if (is_rts) rts <= byte_data[2:0];
              state <= ST_DISCARD;
            end
          end
          ST_WR_ADDR: begin
            ptr   <= byte_data[ADDR_W-1:0];
            state <= ST_WR_DATA;
          end
          ST_WR_DATA: ptr <= ptr + 1'b1;
          ST_RD_ADDR: begin
            ptr   <= byte_data[ADDR_W-1:0];
            state <= ST_RD_DATA;
          end
          ST_RD_DATA: ptr <= ptr + 1'b1;
          ST_BM_ADDR: begin
            ptr   <= byte_data[ADDR_W-1:0];
            state <= ST_BM_MASK;
          end
          ST_BM_MASK: begin
            mask_q <= byte_data;
            state  <= ST_BM_DATA;
          end
          ST_BM_DATA: state <= ST_DISCARD;
          default:    state <= ST_DISCARD;
        endcase
      end
    end
  end

endmodule

// File: rtl/csf_regfile.sv
module csf_regfile
  import csf_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_reset,
  input  logic              spi_wr_en,
  input  logic [ADDR_W-1:0] spi_addr,
  input  logic [7:0]        spi_wr_data,
  output logic [7:0]        spi_rd_data,
  input  logic [ADDR_W-1:0] core_rd_addr,
  output logic [7:0]        core_rd_data,
  input  logic              core_wr_valid,
  output logic              core_wr_ready,
  input  logic [ADDR_W-1:0] core_wr_addr,
  input  logic [7:0]        core_wr_data,
  output logic [2:0]        mode
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] CTRL_IDX = ADDR_W'(15);

  logic [7:0] mem [DEPTH];
  logic [7:0] ctrl_q;
  assign ctrl_q = mem[CTRL_IDX];
  assign mode   = ctrl_q[7:5];

  logic [ADDR_W-1:0] spi_idx, core_idx;
  logic              spi_ok, core_ok;
  assign spi_idx  = (spi_addr[3:0] == NIB_CTRL) ? CTRL_IDX : spi_addr;
  assign core_idx = (core_wr_addr[3:0] == NIB_CTRL) ? CTRL_IDX : core_wr_addr;
  assign spi_ok   = spi_wr_en && (spi_addr[3:0] != NIB_STATUS);
  assign core_ok  = core_wr_valid && core_wr_ready &&
                    (core_wr_addr[3:0] != NIB_STATUS);
  assign core_wr_ready = !(spi_wr_en || soft_reset);

  always_comb begin
    if (spi_addr[3:0] == NIB_STATUS)    spi_rd_data = {ctrl_q[7:5], 5'b0};
    else if (spi_addr[3:0] == NIB_CTRL) spi_rd_data = ctrl_q;
    else                                spi_rd_data = mem[spi_addr];
    if (core_rd_addr[3:0] == NIB_STATUS)    core_rd_data = {ctrl_q[7:5], 5'b0};
    else if (core_rd_addr[3:0] == NIB_CTRL) core_rd_data = ctrl_q;
    else                                    core_rd_data = mem[core_rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= (i == 15) ? CTRL_RESET : 8'h00;
    end else if (soft_reset) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= (i == 15) ? CTRL_RESET : 8'h00;
    end else if (spi_ok) begin
      mem[spi_idx] <= spi_wr_data;
    end else if (core_ok) begin
      mem[core_idx] <= core_wr_data;
    end
  end

endmodule

// File: rtl/can_spi_frontend.sv
module can_spi_frontend #(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic [ADDR_W-1:0] core_rd_addr,
  output logic [7:0]        core_rd_data,
  input  logic              core_wr_valid,
  output logic              core_wr_ready,
  input  logic [ADDR_W-1:0] core_wr_addr,
  input  logic [7:0]        core_wr_data,
  output logic [2:0]        tx_rts,
  output logic [2:0]        op_mode
);

  logic              link_active, byte_valid, wr_en, soft_reset;
  logic [7:0]        byte_data, tx_byte, rd_data, wr_data;
  logic [ADDR_W-1:0] ptr;

  csf_spi_link #(.SYNC_STAGES(SYNC_STAGES)) u_link (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .tx_byte(tx_byte), .miso(spi_miso), .link_active(link_active),
    .byte_valid(byte_valid), .byte_data(byte_data)
  );

  csf_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .link_active(link_active),
    .byte_valid(byte_valid), .byte_data(byte_data), .rd_data(rd_data),
    .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data), .soft_reset(soft_reset),
    .tx_byte(tx_byte), .rts(tx_rts)
  );

  csf_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .soft_reset(soft_reset),
    .spi_wr_en(wr_en), .spi_addr(ptr), .spi_wr_data(wr_data),
    .spi_rd_data(rd_data), .core_rd_addr(core_rd_addr),
    .core_rd_data(core_rd_data), .core_wr_valid(core_wr_valid),
    .core_wr_ready(core_wr_ready), .core_wr_addr(core_wr_addr),
    .core_wr_data(core_wr_data), .mode(op_mode)
  );

endmodule

// File: rtl/csf_checker.sv
module csf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_cs_n,
  input logic       spi_miso,
  input logic       core_wr_valid,
  input logic [2:0] tx_rts,
  input logic [2:0] op_mode
);

  // R6: request-to-send strobes last one cycle
  a_r6_rts_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_rts != 3'b000) |=> (tx_rts == 3'b000));

  // R12: MISO quiet once chip select has been high for a while
  a_r12_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
    |-> !spi_miso);

  // R1: configuration mode right after reset release
  a_r1_reset_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (op_mode == 3'b100));

  // R10: mode moves only through SPI or core writes
  a_r10_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3) &&
     $past(spi_cs_n, 4) && $past(spi_cs_n, 5) && !$past(core_wr_valid))
    |-> $stable(op_mode));

endmodule

bind can_spi_frontend csf_checker u_csf_checker (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
  .core_wr_valid(core_wr_valid), .tx_rts(tx_rts), .op_mode(op_mode)
);

// File: tb/can_spi_frontend_bench.sv
module can_spi_frontend_bench;

  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic       spi_miso;
  logic [6:0] core_rd_addr = '0, core_wr_addr = '0;
  logic [7:0] core_rd_data, core_wr_data = '0;
  logic       core_wr_valid = 1'b0, core_wr_ready;
  logic [2:0] tx_rts, op_mode;

  int checks = 0, errors = 0;
  logic [2:0] rts_seen = '0;
  logic       nr_seen = 1'b0;
  logic [7:0] r, d;

  always #5 clk = ~clk;

  can_spi_frontend u_can_spi_frontend (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .core_rd_addr(core_rd_addr),
    .core_rd_data(core_rd_data), .core_wr_valid(core_wr_valid),
    .core_wr_ready(core_wr_ready), .core_wr_addr(core_wr_addr),
    .core_wr_data(core_wr_data), .tx_rts(tx_rts), .op_mode(op_mode)
  );

  always @(posedge clk) begin
    if (tx_rts != 3'b000) rts_seen <= rts_seen | tx_rts;
    if (core_wr_valid && !core_wr_ready) nr_seen <= 1'b1;
  end

  // addr, init, mask, bits, expected
  localparam logic [39:0] VEC [6] = '{
    40'h00_FF_0F_00_F0,
    40'h25_00_F0_A5_A0,
    40'h33_5A_00_FF_5A,
    40'h7D_12_FF_C3_C3,
    40'h48_AA_55_FF_FF,
    40'h0F_40_E0_20_20
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic spi_bits(input logic [7:0] b, input int n, output logic [7:0] rb);
    rb = '0;
    for (int i = 7; i > 7 - n; i--) begin
      spi_mosi = b[i];
      repeat (HALF) @(negedge clk);
      rb[i] = spi_miso;
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
    end
  endtask

  task automatic spi_byte(input logic [7:0] b, output logic [7:0] rb);
    spi_bits(b, 8, rb);
  endtask

  task automatic cs_lo();
    @(negedge clk) spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic spi_wr1(input logic [7:0] a, input logic [7:0] v);
    logic [7:0] x;
    cs_lo(); spi_byte(8'h02, x); spi_byte(a, x); spi_byte(v, x); cs_hi();
  endtask

  task automatic spi_rd1(input logic [7:0] a, output logic [7:0] v);
    logic [7:0] x;
    cs_lo(); spi_byte(8'h03, x); spi_byte(a, x); spi_byte(8'h00, v); cs_hi();
  endtask

  task automatic spi_bm(input logic [7:0] a, input logic [7:0] m, input logic [7:0] v);
    logic [7:0] x;
    cs_lo(); spi_byte(8'h05, x); spi_byte(a, x); spi_byte(m, x); spi_byte(v, x); cs_hi();
  endtask

  task automatic spi_cmd1(input logic [7:0] op);
    logic [7:0] x;
    cs_lo(); spi_byte(op, x); cs_hi();
  endtask

  task automatic core_rd(input logic [6:0] a, output logic [7:0] v);
    @(negedge clk) core_rd_addr = a;
    #1 v = core_rd_data;
  endtask

  task automatic core_wr(input logic [6:0] a, input logic [7:0] v);
    @(negedge clk);
    core_wr_valid = 1'b1; core_wr_addr = a; core_wr_data = v;
    forever begin
      @(posedge clk);
      if (core_wr_ready) break;
    end
    @(negedge clk) core_wr_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] x, y;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk("R1 mode", {5'b0, op_mode}, 8'h04);
    chk("R1 rts", {5'b0, tx_rts}, 8'h00);
    chk("R1 miso", {7'b0, spi_miso}, 8'h00);
    core_rd(7'h0F, d); chk("R1 control", d, 8'h80);
    core_rd(7'h00, d); chk("R1 reg00", d, 8'h00);
    core_rd(7'h0E, d); chk("R1 status", d, 8'h80);

    // R4 bit modify vectors
    foreach (VEC[k]) begin
      spi_wr1(VEC[k][39:32], VEC[k][31:24]);
      spi_bm(VEC[k][39:32], VEC[k][23:16], VEC[k][15:8]);
      spi_rd1(VEC[k][39:32], r);
      chk("R4 bitmod spi read", r, VEC[k][7:0]);
      core_rd(VEC[k][38:32], d);
      chk("R13 core read", d, VEC[k][7:0]);
    end
    chk("R10 mode sleep", {5'b0, op_mode}, 8'h01);

    // R9 mirroring
    spi_rd1(8'h3E, r); chk("R9 status mirror", r, 8'h20);
    spi_rd1(8'h5F, r); chk("R9 control mirror", r, 8'h20);
    spi_wr1(8'h1E, 8'hFF);
    core_rd(7'h0F, d); chk("R9 status write ignored", d, 8'h20);
    spi_wr1(8'h1F, 8'h60);
    chk("R10 mode listen", {5'b0, op_mode}, 8'h03);
    core_rd(7'h2E, d); chk("R9 status reflects mode", d, 8'h60);

    // R2 / R3 bursts
    cs_lo(); spi_byte(8'h02, x); spi_byte(8'h10, x);
    spi_byte(8'h11, x); spi_byte(8'h22, x); spi_byte(8'h33, x); cs_hi();
    cs_lo(); spi_byte(8'h03, x); spi_byte(8'h10, x);
    spi_byte(8'h00, r); chk("R3 burst0", r, 8'h11);
    spi_byte(8'h00, r); chk("R3 burst1", r, 8'h22);
    spi_byte(8'h00, r); chk("R3 burst2", r, 8'h33);
    cs_hi();
    cs_lo(); spi_byte(8'h02, x); spi_byte(8'h7C, x);
    spi_byte(8'hA1, x); spi_byte(8'hB2, x); spi_byte(8'hEE, x);
    spi_byte(8'h60, x); spi_byte(8'hC3, x); cs_hi();
    core_rd(7'h7D, d); chk("R2 burst 7D", d, 8'hB2);
    core_rd(7'h00, d); chk("R2 wrap to 00", d, 8'hC3);
    chk("R2 control via 7F", {5'b0, op_mode}, 8'h03);
    spi_wr1(8'h93, 8'h5E);
    core_rd(7'h13, d); chk("R2 addr bit7 ignored", d, 8'h5E);

    // R5 transmit buffer loads
    cs_lo(); spi_byte(8'h40, x); spi_byte(8'h01, x); spi_byte(8'h02, x); cs_hi();
    cs_lo(); spi_byte(8'h42, x); spi_byte(8'hDE, x); cs_hi();
    cs_lo(); spi_byte(8'h44, x); spi_byte(8'hBE, x); cs_hi();
    core_rd(7'h31, d); chk("R5 tx0 first", d, 8'h01);
    core_rd(7'h32, d); chk("R5 tx0 next", d, 8'h02);
    core_rd(7'h41, d); chk("R5 tx1", d, 8'hDE);
    core_rd(7'h51, d); chk("R5 tx2", d, 8'hBE);

    // R7 receive buffer reads, core-injected
    core_wr(7'h61, 8'h77); core_wr(7'h62, 8'h88); core_wr(7'h71, 8'h99);
    cs_lo(); spi_byte(8'h90, x);
    spi_byte(8'h00, r); chk("R7 rx0 first", r, 8'h77);
    spi_byte(8'h00, r); chk("R7 rx0 next", r, 8'h88);
    cs_hi();
    cs_lo(); spi_byte(8'h94, x); spi_byte(8'h00, r); cs_hi();
    chk("R7 rx1", r, 8'h99);

    // R6 request to send
    rts_seen = '0; spi_cmd1(8'h85);
    chk("R6 rts 0x85", {5'b0, rts_seen}, 8'h05);
    rts_seen = '0; spi_cmd1(8'h87);
    chk("R6 rts all", {5'b0, rts_seen}, 8'h07);

    // R12 unknown opcode
    cs_lo(); spi_byte(8'hA0, x); spi_byte(8'h02, y);
    spi_byte(8'h10, x); y = y | x; spi_byte(8'hEE, x); y = y | x; cs_hi();
    chk("R12 miso stays 0", y, 8'h00);
    core_rd(7'h10, d); chk("R12 no reg change", d, 8'h11);

    // R11 aborts
    cs_lo(); spi_byte(8'h02, x); spi_byte(8'h10, x); spi_bits(8'h55, 4, x); cs_hi();
    spi_rd1(8'h10, r); chk("R11 partial byte dropped", r, 8'h11);
    cs_lo(); spi_byte(8'h02, x); spi_byte(8'h11, x); cs_hi();
    spi_rd1(8'h11, r); chk("R11 new frame after abort", r, 8'h22);

    // R13 back-pressure: core write held during an SPI write
    @(negedge clk);
    core_wr_valid = 1'b1; core_wr_addr = 7'h21; core_wr_data = 8'h3C;
    nr_seen = 1'b0;
    spi_wr1(8'h20, 8'h5A);
    @(negedge clk) core_wr_valid = 1'b0;
    chk("R13 ready dropped", {7'b0, nr_seen}, 8'h01);
    core_rd(7'h20, d); chk("R13 spi write kept", d, 8'h5A);
    core_rd(7'h21, d); chk("R13 core write done", d, 8'h3C);

    // R8 reset instruction
    spi_cmd1(8'hC0);
    chk("R8 mode config", {5'b0, op_mode}, 8'h04);
    core_rd(7'h10, d); chk("R8 reg cleared", d, 8'h00);
    core_rd(7'h0F, d); chk("R8 control", d, 8'h80);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule